// File: doc/BRIEF.md
# SIMD Array Master Controller

This block is a small single-instruction, multiple-data engine. A master controller steps through a program held in its own control memory. Scalar and control-flow instructions stay inside the controller. Vector instructions are sent to a row of identical processing elements, which all act on them in the same cycle. Each element owns a private data memory and an accumulator, and it operates only on its own data.

A mask register holds one enable bit per element. An element with a clear bit ignores vector instructions, but the data of a neighbour shift still passes through it. Before a run, the host writes the program through a program port and fills the private memories through a load port. It then pulses `start` and waits for `done`. After the run it reads the results back through the same load port.

Every instruction takes three cycles: fetch, decode (which also issues the operand read in every element) and execute. The mask and the scalar register keep their values from one run to the next and change only on reset or when an instruction writes them.

Top module: `simd_array_top`

## Requirements
- R1: An instruction is 16 bits: opcode in [15:12], immediate in [7:0]. The opcode values are 1 scalar-load-immediate, 2 scalar-add, 3 branch-if-zero, 4 jump, 5 set-mask, 8 vector-load, 9 vector-add, 10 vector-multiply, 11 vector-store, 12 neighbour-shift and 15 halt. Any other value does nothing. After `start`, fetching begins at program address 0 and continues one instruction after another.
- R2: Scalar-load-immediate writes the immediate to the scalar register, and scalar-add adds the immediate to it modulo 2^DW. Neither touches any element's accumulator or memory. The scalar register is visible on `scalar_val`.
- R3: Jump loads the program counter with imm[PCW-1:0]. Branch-if-zero does the same only when the scalar register is zero, and otherwise falls through to the next address.
- R4: In every enabled element, vector-load copies private word imm[AW-1:0] into the accumulator. Vector-add adds that word to the accumulator, and vector-multiply keeps the low DW bits of the product. Vector-store writes the accumulator to that word. Arithmetic is modulo 2^DW.
- R5: An element whose mask bit is 0 leaves both its accumulator and its private memory unchanged when a vector instruction executes.
- R6: Set-mask loads the mask with imm[N_PE-1:0]; bit i enables element i. After reset the mask is all ones. The mask is visible on `mask_val`.
- R7: Halt stops fetching. It raises `done` and lowers `busy`, and `done` stays high until the next `start`.
- R8: In a neighbour shift, each enabled element i>0 takes the accumulator value that element i-1 held before the shift, whether or not element i-1 is enabled. An enabled element 0 takes zero.
- R9: A load-port write goes to word `ld_addr` of the element selected by `ld_pe`. A read returns that word on `ld_rdata` one clock after the address is presented. Load-port and program-port writes are ignored while `busy` is high.
- R10: After reset, `busy` and `done` are low, `scalar_val` is zero and `mask_val` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Program memory write strobe |
| prog_addr | input | PCW | Program memory write address |
| prog_data | input | 16 | Instruction word to write |
| start | input | 1 | Begin a run at program address 0 |
| ld_we | input | 1 | Private memory write strobe |
| ld_pe | input | PEW | Selected processing element |
| ld_addr | input | AW | Private memory word address |
| ld_wdata | input | DW | Private memory write data |
| ld_rdata | output | DW | Private memory read data, one-cycle latency |
| busy | output | 1 | Program running |
| done | output | 1 | Halt reached |
| scalar_val | output | DW | Scalar register |
| mask_val | output | N_PE | Element enable mask |

## Verification
The bench builds the block with its defaults: four elements, 8-bit data, 16-word private memories and a 16-entry program memory. Four elements are enough to place a disabled element inside the neighbour-shift chain, with enabled elements on both sides of it. Sums and products that overflow eight bits, together with a countdown loop, exercise the modulo arithmetic and both outcomes of the conditional branch.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int IW = 16;

  typedef enum logic [3:0] {
    OP_NOP   = 4'h0,
    OP_SLI   = 4'h1,
    OP_SADD  = 4'h2,
    OP_BRZ   = 4'h3,
    OP_JMP   = 4'h4,
    OP_SMASK = 4'h5,
    OP_VLD   = 4'h8,
    OP_VADD  = 4'h9,
    OP_VMUL  = 4'hA,
    OP_VST   = 4'hB,
    OP_VSHN  = 4'hC,
    OP_HALT  = 4'hF
  } opcode_t;

  typedef enum logic [2:0] {
    C_IDLE, C_FETCH, C_DEC, C_EXE, C_DONE
  } cstate_t;
endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl import simd_pkg::*; #(
  parameter int N_PE       = 4,
  parameter int DW         = 8,
  parameter int PROG_DEPTH = 16,
  parameter int AW         = 4,
  localparam int PCW       = $clog2(PROG_DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            prog_we,
  input  logic [PCW-1:0]  prog_addr,
  input  logic [IW-1:0]   prog_data,
  input  logic            start,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   scalar_val,
  output logic [N_PE-1:0] mask_val,
  output logic            vec_valid,
  output opcode_t         vec_op,
  output logic [AW-1:0]   vec_addr
);
  logic [IW-1:0]   imem [PROG_DEPTH];
  logic [IW-1:0]   ir_q;
  logic [PCW-1:0]  pc_q;
  logic [DW-1:0]   sreg_q;
  logic [N_PE-1:0] mask_q;
  cstate_t         st_q;
  opcode_t         op;
  logic [7:0]      imm;
  logic            is_vec;

  assign op       = opcode_t'(ir_q[IW-1:IW-4]);
  assign imm      = ir_q[7:0];
  assign is_vec   = (op == OP_VLD) || (op == OP_VADD) || (op == OP_VMUL) ||
                    (op == OP_VST) || (op == OP_VSHN);
  assign busy     = (st_q == C_FETCH) || (st_q == C_DEC) || (st_q == C_EXE);
  assign done     = (st_q == C_DONE);
  assign scalar_val = sreg_q;
  assign mask_val = mask_q;
  assign vec_valid = (st_q == C_EXE) && is_vec;
  assign vec_op   = op;
  assign vec_addr = ir_q[AW-1:0];

  // Program store: one write port, registered read for block RAM.
  always_ff @(posedge clk) begin
    if (prog_we && !busy) imem[prog_addr] <= prog_data;
    ir_q <= imem[pc_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= C_IDLE;
      pc_q   <= '0;
      sreg_q <= '0;
      mask_q <= '1;
    end else begin
      case (st_q)
        C_IDLE, C_DONE: if (start) begin
          pc_q <= '0;
          st_q <= C_FETCH;
        end
        C_FETCH: st_q <= C_DEC;
        C_DEC:   st_q <= C_EXE;
        C_EXE: begin
          st_q <= C_FETCH;
          pc_q <= pc_q + 1'b1;
          case (op)
            OP_SLI:   sreg_q <= DW'(imm);
            OP_SADD:  sreg_q <= sreg_q + DW'(imm);
            OP_BRZ:   if (sreg_q == '0) pc_q <= imm[PCW-1:0];
            OP_JMP:   pc_q <= imm[PCW-1:0];
            OP_SMASK: mask_q <= imm[N_PE-1:0];
            OP_HALT:  st_q <= C_DONE;
            default:  ;
          endcase
        end
        default: st_q <= C_IDLE;
      endcase
    end
  end

  p_jump_target_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == C_EXE && op == OP_JMP) |=> pc_q == $past(ir_q[PCW-1:0]));
  p_mask_load_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == C_EXE && op == OP_SMASK) |=> mask_val == $past(ir_q[N_PE-1:0]));
  p_halt_done_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == C_EXE && op == OP_HALT) |=> (done && !busy));
  p_done_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
endmodule

// File: rtl/simd_pe.sv
module simd_pe import simd_pkg::*; #(
  parameter int DW        = 8,
  parameter int MEM_DEPTH = 16,
  localparam int AW       = $clog2(MEM_DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ext_we,
  input  logic [AW-1:0] ext_addr,
  input  logic [DW-1:0] ext_wdata,
  input  logic [AW-1:0] rd_addr,
  input  logic          vec_valid,
  input  opcode_t       vec_op,
  input  logic [AW-1:0] vec_addr,
  input  logic          en,
  input  logic [DW-1:0] nb_in,
  output logic [DW-1:0] acc_out,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [MEM_DEPTH];
  logic [DW-1:0] rd_q;
  logic [DW-1:0] acc_q;
  logic          act;
  logic          mem_we;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  assign act     = vec_valid && en;
  assign mem_we  = ext_we || (act && vec_op == OP_VST);
  assign wr_addr = ext_we ? ext_addr : vec_addr;
  assign wr_data = ext_we ? ext_wdata : acc_q;
  assign acc_out = acc_q;
  assign rd_data = rd_q;

  // Private store: single write port, registered read.
  always_ff @(posedge clk) begin
    if (mem_we) mem[wr_addr] <= wr_data;
    rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (act) begin
      case (vec_op)
        OP_VLD:  acc_q <= rd_q;
        OP_VADD: acc_q <= acc_q + rd_q;
        OP_VMUL: acc_q <= acc_q * rd_q;
        OP_VSHN: acc_q <= nb_in;
        default: ;
      endcase
    end
  end

  p_masked_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && !en) |=> $stable(acc_out));
  p_masked_nowrite_r5: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && !en) |-> !mem_we);
  p_acc_vector_only_r2: assert property (@(posedge clk) disable iff (rst)
    !vec_valid |=> $stable(acc_out));
endmodule

// File: rtl/simd_array_top.sv
module simd_array_top import simd_pkg::*; #(
  parameter int N_PE       = 4,
  parameter int DW         = 8,
  parameter int MEM_DEPTH  = 16,
  parameter int PROG_DEPTH = 16,
  localparam int AW        = $clog2(MEM_DEPTH),
  localparam int PCW       = $clog2(PROG_DEPTH),
  localparam int PEW       = (N_PE > 1) ? $clog2(N_PE) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            prog_we,
  input  logic [PCW-1:0]  prog_addr,
  input  logic [15:0]     prog_data,
  input  logic            start,
  input  logic            ld_we,
  input  logic [PEW-1:0]  ld_pe,
  input  logic [AW-1:0]   ld_addr,
  input  logic [DW-1:0]   ld_wdata,
  output logic [DW-1:0]   ld_rdata,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   scalar_val,
  output logic [N_PE-1:0] mask_val
);
  logic            vec_valid;
  opcode_t         vec_op;
  logic [AW-1:0]   vec_addr;
  logic [AW-1:0]   rd_addr;
  logic [PEW-1:0]  sel_q;
  logic [DW-1:0]   acc_w [N_PE];
  logic [DW-1:0]   rd_w  [N_PE];

  simd_ctrl #(.N_PE(N_PE), .DW(DW), .PROG_DEPTH(PROG_DEPTH), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .start(start), .busy(busy), .done(done),
    .scalar_val(scalar_val), .mask_val(mask_val), .vec_valid(vec_valid),
    .vec_op(vec_op), .vec_addr(vec_addr)
  );

  assign rd_addr = busy ? vec_addr : ld_addr;

  for (genvar i = 0; i < N_PE; i++) begin : g_pe
    logic [DW-1:0] nb;
    logic          ext_we;
    if (i == 0) begin : g_head
      assign nb = '0;
    end else begin : g_link
      assign nb = acc_w[i-1];
    end
    assign ext_we = ld_we && !busy && (ld_pe == PEW'(i));
    simd_pe #(.DW(DW), .MEM_DEPTH(MEM_DEPTH)) u_pe (
      .clk(clk), .rst(rst), .ext_we(ext_we), .ext_addr(ld_addr),
      .ext_wdata(ld_wdata), .rd_addr(rd_addr), .vec_valid(vec_valid),
      .vec_op(vec_op), .vec_addr(vec_addr), .en(mask_val[i]), .nb_in(nb),
      .acc_out(acc_w[i]), .rd_data(rd_w[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else     sel_q <= ld_pe;
  end
  assign ld_rdata = rd_w[sel_q];

  p_no_write_busy_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> !g_pe[0].ext_we);
endmodule

// File: tb/simd_array_top_test.sv
module simd_array_top_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        prog_we = 0;
  logic [3:0]  prog_addr = '0;
  logic [15:0] prog_data = '0;
  logic        start = 0;
  logic        ld_we = 0;
  logic [1:0]  ld_pe = '0;
  logic [3:0]  ld_addr = '0;
  logic [7:0]  ld_wdata = '0;
  logic [7:0]  ld_rdata;
  logic        busy, done;
  logic [7:0]  scalar_val;
  logic [3:0]  mask_val;

  int checks = 0;
  int errors = 0;

  localparam logic [7:0] A [4] = '{8'd10, 8'd200, 8'd37, 8'd128};
  localparam logic [7:0] B [4] = '{8'd5, 8'd100, 8'd19, 8'd128};

  simd_array_top uut (.*);

  always #10 clk = ~clk;

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(logic [3:0] op, logic [7:0] imm);
    return {op, 4'h0, imm};
  endfunction

  task automatic put_ins(int a, logic [15:0] w);
    @(negedge clk);
    prog_we = 1; prog_addr = 4'(a); prog_data = w;
    @(negedge clk);
    prog_we = 0;
  endtask

  task automatic pe_wr(int pe, int a, logic [7:0] d);
    @(negedge clk);
    ld_we = 1; ld_pe = 2'(pe); ld_addr = 4'(a); ld_wdata = d;
    @(negedge clk);
    ld_we = 0;
  endtask

  task automatic pe_rd(int pe, int a, output logic [7:0] d);
    @(negedge clk);
    ld_pe = 2'(pe); ld_addr = 4'(a);
    @(negedge clk);
    d = ld_rdata;
  endtask

  task automatic run_prog();
    int n = 0;
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk("R7 halt reached", done, 1);
  endtask

  task automatic t_reset();
    chk("R10 busy", busy, 0);
    chk("R10 done", done, 0);
    chk("R10 scalar", scalar_val, 0);
    chk("R10 mask", mask_val, 4'hF);
  endtask

  task automatic t_loadport();
    logic [7:0] d;
    for (int i = 0; i < 4; i++) pe_wr(i, 15, 8'(8'h30 + i));
    for (int i = 0; i < 4; i++) begin
      pe_rd(i, 15, d);
      chk("R9 load port readback", d, 8'(8'h30 + i));
    end
  endtask

  task automatic t_vadd();
    logic [7:0] d;
    for (int i = 0; i < 4; i++) begin pe_wr(i, 0, A[i]); pe_wr(i, 1, B[i]); end
    put_ins(0, ins(4'h5, 8'h0F));
    put_ins(1, ins(4'h8, 8'd0));
    put_ins(2, ins(4'h9, 8'd1));
    put_ins(3, ins(4'hB, 8'd2));
    put_ins(4, ins(4'hF, 8'd0));
    run_prog();
    for (int i = 0; i < 4; i++) begin
      pe_rd(i, 2, d);
      chk("R4 vector add wraps", d, 8'(A[i] + B[i]));
    end
    repeat (5) @(negedge clk);
    chk("R7 done held", done, 1);
    chk("R7 busy low", busy, 0);
  endtask

  task automatic t_vmul_mask();
    logic [7:0] d;
    logic [7:0] exp;
    for (int i = 0; i < 4; i++) pe_wr(i, 3, 8'hEE);
    put_ins(0, ins(4'h5, 8'h05));
    put_ins(1, ins(4'h8, 8'd0));
    put_ins(2, ins(4'hA, 8'd1));
    put_ins(3, ins(4'hB, 8'd3));
    put_ins(4, ins(4'hF, 8'd0));
    run_prog();
    chk("R6 mask value", mask_val, 4'h5);
    for (int i = 0; i < 4; i++) begin
      pe_rd(i, 3, d);
      exp = (i % 2 == 0) ? 8'(A[i] * B[i]) : 8'hEE;
      chk((i % 2 == 0) ? "R4 vector multiply" : "R5 masked element unchanged", d, exp);
    end
  endtask

  task automatic t_shift();
    logic [7:0] d;
    logic [7:0] exp [4];
    exp = '{8'd0, A[0], A[2], A[2]};
    put_ins(0, ins(4'h5, 8'h0F));
    put_ins(1, ins(4'h8, 8'd0));
    put_ins(2, ins(4'h5, 8'h0B));
    put_ins(3, ins(4'hC, 8'd0));
    put_ins(4, ins(4'h5, 8'h0F));
    put_ins(5, ins(4'hB, 8'd4));
    put_ins(6, ins(4'hF, 8'd0));
    run_prog();
    for (int i = 0; i < 4; i++) begin
      pe_rd(i, 4, d);
      chk("R8 neighbour shift", d, exp[i]);
    end
  endtask

  task automatic t_scalar();
    logic [7:0] d;
    put_ins(0, ins(4'h5, 8'h0F));
    put_ins(1, ins(4'h8, 8'd0));
    put_ins(2, ins(4'h1, 8'h2A));
    put_ins(3, ins(4'h2, 8'h01));
    put_ins(4, ins(4'hB, 8'd8));
    put_ins(5, ins(4'hF, 8'd0));
    run_prog();
    chk("R2 scalar add", scalar_val, 8'h2B);
    for (int i = 0; i < 4; i++) begin
      pe_rd(i, 8, d);
      chk("R2 accumulator untouched by scalar ops", d, A[i]);
    end
  endtask

  task automatic t_loop_busy();
    logic [7:0] d;
    for (int i = 0; i < 4; i++) begin pe_wr(i, 6, 8'd0); pe_wr(i, 7, 8'(i + 1)); end
    pe_wr(0, 9, 8'h11);
    put_ins(0, ins(4'h5, 8'h0F));
    put_ins(1, ins(4'h1, 8'd3));
    put_ins(2, ins(4'h8, 8'd6));
    put_ins(3, ins(4'h9, 8'd7));
    put_ins(4, ins(4'hB, 8'd6));
    put_ins(5, ins(4'h2, 8'hFF));
    put_ins(6, ins(4'h3, 8'd8));
    put_ins(7, ins(4'h4, 8'd2));
    put_ins(8, ins(4'hF, 8'd0));
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    chk("R1 busy after start", busy, 1);
    ld_we = 1; ld_pe = 0; ld_addr = 4'd9; ld_wdata = 8'h55;
    prog_we = 1; prog_addr = 4'd8; prog_data = ins(4'h0, 8'd0);
    @(negedge clk);
    ld_we = 0; prog_we = 0;
    for (int n = 0; n < 3000 && !done; n++) @(negedge clk);
    chk("R3 loop halts via branch", done, 1);
    chk("R3 countdown scalar", scalar_val, 0);
    for (int i = 0; i < 4; i++) begin
      pe_rd(i, 6, d);
      chk("R3 loop iterations", d, 8'(3 * (i + 1)));
    end
    pe_rd(0, 9, d);
    chk("R9 load write ignored while busy", d, 8'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_loadport();
    t_vadd();
    t_vmul_mask();
    t_shift();
    t_scalar();
    t_loop_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule